// File: doc/BRIEF.md
# Multi-Source Chip Reset Sequencer

This block merges every reset request of a small microcontroller into one chip-wide reset. The requests are power-on, a filtered external active-low pin, a watchdog time-out, a brown-out detect and a program-memory parity error. It records which request caused the last reset, so that boot code can branch on it. It also keeps the two legacy status flags, a time-out flag and a power-down flag, which take a different pair of values for each kind of event.

The chip reset is a set/clear latch. Any request sets it. It clears only after two cascaded start-up counters have expired. The first counter counts rising edges of a separate slow on-chip clock. The second counter counts main-clock cycles, and it starts only after the first one has finished. Either counter can be switched off, and a switched-off counter adds no cycles. A watchdog time-out that arrives while the core sleeps is treated as a wake-up. It updates the flags and the cause code but leaves the chip reset alone. The external pin is only ever read by this block and is never driven.

Top module: `rst_sequencer`

## Requirements
- R1: While `por_pulse` is high, and after it falls, `chip_rst` is 1, `to_flag`=1, `pd_flag`=1 and `cause_code`=1 until the enabled start-up counters expire.
- R2: A low level on `ext_rst_n` that lasts fewer than FILT_LEN consecutive clock samples has no effect. A low level of FILT_LEN or more samples raises `chip_rst` at the FILT_LEN-th edge.
- R3: A filtered pin reset while `sleeping`=0 sets `cause_code`=2 and leaves both flags unchanged. With `sleeping`=1 it sets `cause_code`=3, `to_flag`=1 and `pd_flag`=0.
- R4: A watchdog time-out while `sleeping`=0 raises `chip_rst` and sets `cause_code`=4, `to_flag`=0 and `pd_flag`=1.
- R5: A watchdog time-out while `sleeping`=1 and `chip_rst`=0 never raises `chip_rst`. It sets `cause_code`=7, `to_flag`=0 and `pd_flag`=0.
- R6: A brown-out detect with `bor_en`=1 raises `chip_rst` and sets `cause_code`=5 and both flags to 1. With `bor_en`=0 the detect is ignored.
- R7: A parity error with `parity_en`=1 raises `chip_rst` and sets `cause_code`=6 and both flags to 1. With `parity_en`=0 the error is ignored.
- R8: When requests arrive in the same cycle, the cause follows the priority brown-out, then parity, then watchdog, then pin.
- R9: With both counters disabled, `chip_rst` falls at the first edge after the last edge that sampled a request.
- R10: With only the main-clock counter enabled, `chip_rst` falls at the (2^CNT_W+1)-th edge after the last edge that sampled a request.
- R11: With the slow-clock counter enabled, reset is held for 2^CNT_W synchronised slow-clock rising edges. Only after that does the main-clock counter advance.
- R12: Any request sets `chip_rst` at the next edge. A request that arrives while reset is held restarts both counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| por_pulse | input | 1 | Power-on detect, active high, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low, read only |
| wdt_timeout | input | 1 | Watchdog time-out pulse |
| sleeping | input | 1 | Core is in sleep state |
| bor_detect | input | 1 | Brown-out detector output |
| bor_en | input | 1 | Enables brown-out reset |
| parity_err | input | 1 | Program-memory parity error |
| parity_en | input | 1 | Enables parity reset |
| pwrt_en | input | 1 | Enables slow-clock power-up counter |
| ost_en | input | 1 | Enables main-clock start-up counter |
| slow_clk | input | 1 | Separate on-chip slow clock |
| chip_rst | output | 1 | Held chip reset |
| to_flag | output | 1 | Time-out status flag |
| pd_flag | output | 1 | Power-down status flag |
| cause_code | output | 3 | Code of the last reset or wake event |

## Verification
Some properties are checked on every cycle. A filtered pin request is only ever preceded by a low pin. Every request sets the latch. The latch only rises after a request, never after a wake-up. It only falls once both counters report done. The main-clock counter only moves after the slow counter is done. A wake leaves both flags cleared. The bench scenarios are needed to show the exact hold lengths for each pair of counter enables and the cut-off pulse width of the glitch filter. They also cover the full walk through the flag encodings, the ignoring of disabled sources, and the priority between simultaneous requests.

// File: rtl/rst_pkg.sv
package rst_pkg;

  typedef enum logic [2:0] {
    CZ_NONE      = 3'd0,
    CZ_POWERON   = 3'd1,
    CZ_PIN_RUN   = 3'd2,
    CZ_PIN_SLEEP = 3'd3,
    CZ_DOG_RUN   = 3'd4,
    CZ_BROWNOUT  = 3'd5,
    CZ_PARITY    = 3'd6,
    CZ_DOG_WAKE  = 3'd7
  } cause_e;

  // Priority: brown-out > parity > watchdog (running) > pin > watchdog wake
  function automatic cause_e pick_cause(input logic bor, input logic par,
                                        input logic dog, input logic pin,
                                        input logic slp);
    cause_e c;
    if (bor)              c = CZ_BROWNOUT;
    else if (par)         c = CZ_PARITY;
    else if (dog && !slp) c = CZ_DOG_RUN;
    else if (pin)         c = slp ? CZ_PIN_SLEEP : CZ_PIN_RUN;
    else if (dog)         c = CZ_DOG_WAKE;
    else                  c = CZ_NONE;
    return c;
  endfunction

  // Returns {to, pd} after an event of the given kind
  function automatic logic [1:0] flags_for(input cause_e c, input logic to_q,
                                           input logic pd_q);
    logic [1:0] f;
    case (c)
      CZ_POWERON, CZ_BROWNOUT, CZ_PARITY: f = 2'b11;
      CZ_DOG_RUN:   f = 2'b01;
      CZ_DOG_WAKE:  f = 2'b00;
      CZ_PIN_SLEEP: f = 2'b10;
      default:      f = {to_q, pd_q};
    endcase
    return f;
  endfunction

  function automatic logic is_reset_cause(input cause_e c);
    return (c != CZ_NONE) && (c != CZ_DOG_WAKE);
  endfunction

endpackage

// File: rtl/rst_glitch_filter.sv
module rst_glitch_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic por,
  input  logic pin_n,
  output logic pin_req
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or posedge por) begin
    if (por)            low_cnt <= '0;
    else if (pin_n)     low_cnt <= '0;
    else if (low_cnt < LAST) low_cnt <= low_cnt + 1'b1;
  end

  // The FILT_LEN-th consecutive low sample, and every later one, is a request
  assign pin_req = !pin_n && (low_cnt == LAST);

  p_low_only_r2: assert property (@(posedge clk) disable iff (por)
    pin_req |-> !$past(pin_n));

endmodule

// File: rtl/rst_startup_timer.sv
module rst_startup_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             por,
  input  logic             restart,
  input  logic             en,
  input  logic             advance,
  output logic [CNT_W:0]   count,
  output logic             done
);
  localparam logic [CNT_W:0] FULL = (CNT_W+1)'(1) << CNT_W;

  always_ff @(posedge clk or posedge por) begin
    if (por)                               count <= '0;
    else if (restart)                      count <= '0;
    else if (en && advance && !count[CNT_W]) count <= count + 1'b1;
  end

  // A disabled counter is bypassed in zero cycles
  assign done = !en || count[CNT_W];

  p_cap_r11: assert property (@(posedge clk) disable iff (por)
    count <= FULL);

endmodule

// File: rtl/rst_cause_tracker.sv
module rst_cause_tracker
  import rst_pkg::*;
(
  input  logic   clk,
  input  logic   por,
  input  logic   update,
  input  cause_e event_cause,
  output logic   to_flag,
  output logic   pd_flag,
  output cause_e cause
);
  logic [1:0] nxt;
  assign nxt = flags_for(event_cause, to_flag, pd_flag);

  always_ff @(posedge clk or posedge por) begin
    if (por) begin
      to_flag <= 1'b1;
      pd_flag <= 1'b1;
      cause   <= CZ_POWERON;
    end else if (update) begin
      {to_flag, pd_flag} <= nxt;
      cause <= event_cause;
    end
  end

  p_wake_flags_r5: assert property (@(posedge clk) disable iff (por)
    (update && event_cause == CZ_DOG_WAKE) |=> (!to_flag && !pd_flag));

  p_pin_run_keeps_r3: assert property (@(posedge clk) disable iff (por)
    (update && event_cause == CZ_PIN_RUN) |=> $stable({to_flag, pd_flag}));

endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
  import rst_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int FILT_LEN = 4
) (
  input  logic       clk,
  input  logic       por_pulse,
  input  logic       ext_rst_n,
  input  logic       wdt_timeout,
  input  logic       sleeping,
  input  logic       bor_detect,
  input  logic       bor_en,
  input  logic       parity_err,
  input  logic       parity_en,
  input  logic       pwrt_en,
  input  logic       ost_en,
  input  logic       slow_clk,
  output logic       chip_rst,
  output logic       to_flag,
  output logic       pd_flag,
  output logic [2:0] cause_code
);
  // Named internal events
  logic       pin_req, bor_req, par_req;
  cause_e     ev_cause, cause_q;
  logic       any_req, wake_evt, slow_tick;
  logic       pwrt_done, ost_done;
  logic [CNT_W:0] pwrt_count, ost_count;
  logic [2:0] slow_sync;

  rst_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filter (
    .clk(clk), .por(por_pulse), .pin_n(ext_rst_n), .pin_req(pin_req));

  assign bor_req  = bor_en && bor_detect;
  assign par_req  = parity_en && parity_err;
  assign ev_cause = pick_cause(bor_req, par_req, wdt_timeout, pin_req, sleeping);
  assign any_req  = is_reset_cause(ev_cause);
  assign wake_evt = (ev_cause == CZ_DOG_WAKE) && !chip_rst;

  // Slow clock brought into the main domain as a rising-edge tick
  always_ff @(posedge clk or posedge por_pulse) begin
    if (por_pulse) slow_sync <= '0;
    else           slow_sync <= {slow_sync[1:0], slow_clk};
  end
  assign slow_tick = slow_sync[1] && !slow_sync[2];

  rst_startup_timer #(.CNT_W(CNT_W)) u_pwrt (
    .clk(clk), .por(por_pulse), .restart(any_req), .en(pwrt_en),
    .advance(chip_rst && slow_tick), .count(pwrt_count), .done(pwrt_done));

  rst_startup_timer #(.CNT_W(CNT_W)) u_ost (
    .clk(clk), .por(por_pulse), .restart(any_req), .en(ost_en),
    .advance(chip_rst && pwrt_done), .count(ost_count), .done(ost_done));

  // Set/clear latch for the chip reset
  always_ff @(posedge clk or posedge por_pulse) begin
    if (por_pulse)                   chip_rst <= 1'b1;
    else if (any_req)                chip_rst <= 1'b1;
    else if (pwrt_done && ost_done)  chip_rst <= 1'b0;
  end

  rst_cause_tracker u_cause (
    .clk(clk), .por(por_pulse), .update(any_req || wake_evt),
    .event_cause(ev_cause), .to_flag(to_flag), .pd_flag(pd_flag),
    .cause(cause_q));

  assign cause_code = cause_q;

  p_set_r12: assert property (@(posedge clk) disable iff (por_pulse)
    any_req |=> chip_rst);

  p_rise_from_req_r5: assert property (@(posedge clk) disable iff (por_pulse)
    $rose(chip_rst) |-> $past(any_req));

  p_release_r9: assert property (@(posedge clk) disable iff (por_pulse)
    $fell(chip_rst) |-> $past(pwrt_done && ost_done));

  p_order_r11: assert property (@(posedge clk) disable iff (por_pulse)
    (ost_count != $past(ost_count) && ost_count != '0) |-> $past(pwrt_done));

endmodule

// File: tb/test_rst_sequencer.sv
`timescale 1ns/1ps
module test_rst_sequencer;
  localparam int W  = 4;
  localparam int FL = 4;
  localparam int SLOW_HALF = 4;   // main cycles per slow-clock half period

  logic clk = 0, slow_clk = 0;
  logic por_pulse, ext_rst_n, wdt_timeout, sleeping, bor_detect, bor_en;
  logic parity_err, parity_en, pwrt_en, ost_en;
  logic chip_rst, to_flag, pd_flag;
  logic [2:0] cause_code;

  int n_chk = 0, n_bad = 0;
  bit seen_rst = 0;
  bit finished = 0;

  always #10 clk = ~clk;
  always #(20*SLOW_HALF) slow_clk = ~slow_clk;

  rst_sequencer #(.CNT_W(W), .FILT_LEN(FL)) i_rst_sequencer (
    .clk(clk), .por_pulse(por_pulse), .ext_rst_n(ext_rst_n),
    .wdt_timeout(wdt_timeout), .sleeping(sleeping), .bor_detect(bor_detect),
    .bor_en(bor_en), .parity_err(parity_err), .parity_en(parity_en),
    .pwrt_en(pwrt_en), .ost_en(ost_en), .slow_clk(slow_clk),
    .chip_rst(chip_rst), .to_flag(to_flag), .pd_flag(pd_flag),
    .cause_code(cause_code));

  always @(negedge clk) if (chip_rst) seen_rst = 1;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_range(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic chk_status(input string req, input int c, input int t, input int p);
    chk({req, " cause"}, int'(cause_code), c);
    chk({req, " to"}, int'(to_flag), t);
    chk({req, " pd"}, int'(pd_flag), p);
  endtask

  // Drive request lines for exactly one clock edge
  task automatic pulse(input bit b, input bit p, input bit w);
    @(negedge clk);
    bor_detect = b; parity_err = p; wdt_timeout = w;
    @(negedge clk);
    bor_detect = 0; parity_err = 0; wdt_timeout = 0;
  endtask

  task automatic pin_low(input int w);
    @(negedge clk);
    ext_rst_n = 0;
    repeat (w) @(negedge clk);
    ext_rst_n = 1;
  endtask

  // Number of negedge samples with chip_rst high, from the current negedge
  task automatic measure(output int n);
    n = 0;
    while (chip_rst && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  function automatic int ost_len(input bit en);
    return en ? (1 << W) : 0;
  endfunction

  initial begin
    #(20*150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    por_pulse = 1; ext_rst_n = 1; wdt_timeout = 0; sleeping = 0;
    bor_detect = 0; bor_en = 1; parity_err = 0; parity_en = 1;
    pwrt_en = 0; ost_en = 1;
    repeat (3) @(negedge clk);
    chk("R1 rst during por", int'(chip_rst), 1);
    chk_status("R1", 1, 1, 1);
    por_pulse = 0;
    measure(n);
    chk("R1/R10 por hold", n, ost_len(1) + 1);
    chk_status("R1 after", 1, 1, 1);

    // Sweep the counter enables with a running watchdog reset
    for (int cfg = 0; cfg < 4; cfg++) begin
      pwrt_en = cfg[1]; ost_en = cfg[0];
      repeat (3) @(negedge clk);
      pulse(0, 0, 1);
      measure(n);
      if (!pwrt_en)
        chk(ost_en ? "R10 ost-only hold" : "R9 no-counter hold", n, ost_len(ost_en) + 1);
      else
        chk_range("R11 slow counter hold", n,
                  ((1 << W) - 1) * 2 * SLOW_HALF + ost_len(ost_en),
                  (1 << W) * 2 * SLOW_HALF + 2 * SLOW_HALF + ost_len(ost_en) + 4);
      chk_status("R4 dog run", 4, 0, 1);
    end

    // Glitch filter sweep with counters off
    pwrt_en = 0; ost_en = 0;
    for (int w = 1; w <= 6; w++) begin
      repeat (3) @(negedge clk);
      seen_rst = 0;
      pin_low(w);
      repeat (4) @(negedge clk);
      chk("R2 filter", int'(seen_rst), (w >= FL) ? 1 : 0);
      if (w >= FL) chk_status("R3 pin run", 2, 0, 1);
      else         chk_status("R2 glitch ignored", 4, 0, 1);
    end

    // Pin during sleep
    sleeping = 1;
    pin_low(FL + 1);
    repeat (3) @(negedge clk);
    chk_status("R3 pin sleep", 3, 1, 0);

    // Watchdog wake from sleep
    seen_rst = 0;
    pulse(0, 0, 1);
    repeat (4) @(negedge clk);
    chk("R5 wake no reset", int'(seen_rst), 0);
    chk_status("R5 wake", 7, 0, 0);
    sleeping = 0;

    // Disabled and enabled brown-out / parity
    bor_en = 0; seen_rst = 0;
    pulse(1, 0, 0);
    repeat (3) @(negedge clk);
    chk("R6 bor disabled", int'(seen_rst), 0);
    chk_status("R6 disabled keeps", 7, 0, 0);
    bor_en = 1;
    pulse(1, 0, 0);
    repeat (3) @(negedge clk);
    chk("R6 bor enabled", int'(seen_rst), 1);
    chk_status("R6 bor", 5, 1, 1);

    pulse(0, 0, 1);
    repeat (3) @(negedge clk);
    parity_en = 0; seen_rst = 0;
    pulse(0, 1, 0);
    repeat (3) @(negedge clk);
    chk("R7 parity disabled", int'(seen_rst), 0);
    chk_status("R7 disabled keeps", 4, 0, 1);
    parity_en = 1;
    pulse(0, 1, 0);
    repeat (3) @(negedge clk);
    chk("R7 parity enabled", int'(seen_rst), 1);
    chk_status("R7 parity", 6, 1, 1);

    // Priority
    pulse(1, 1, 1);
    repeat (3) @(negedge clk);
    chk("R8 bor first", int'(cause_code), 5);
    pulse(0, 1, 1);
    repeat (3) @(negedge clk);
    chk("R8 parity over dog", int'(cause_code), 6);

    // Restart while held
    ost_en = 1;
    pulse(0, 0, 1);
    repeat (6) @(negedge clk);
    chk("R12 still held", int'(chip_rst), 1);
    pulse(0, 0, 1);
    measure(n);
    chk("R12 restart hold", n, ost_len(1) + 1);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule